// File: doc/BRIEF.md
# Priority Port-to-Pad Multiplexer

This block sits between a tile's logical I/O ports and its 64 physical pads. Ports come in five widths: sixteen 1-bit, six 4-bit, four 8-bit, two 16-bit and one 32-bit. Most pads carry a bit of several ports at once, so the block settles, pad by pad, which source may drive. Among enabled output ports the narrowest one wins.

Three side functions can claim any pad and override every port: a serial link, a memory interface and a clock output. Two PHY modes take whole ports away from the application. They still let the 4-bit ports that lie underneath the stolen 8-bit ports reach their pads. In the other direction, each pad value is copied to every port bit wired to it, and the arbitration has no say in that.

The configuration inputs are registered once per clock. These are the port enables and directions, the side-function claims and the two PHY mode bits. The data paths are combinational: port output data, side data and side drive enables in one direction, pad inputs in the other.

Top module: `padmux_top`

## Requirements
- R1: After reset, no pad is driven (`padOe` all 0) and every pad has its pull-down asserted (`padPullDn` all 1). This holds until a configuration is loaded.
- R2: On a pad claimed by several enabled output ports, the source is picked in a fixed order. The 1-bit port comes first, then the 4-bit, 8-bit, 16-bit and 32-bit ports. The pad takes the winner's data bit and `padOe` is 1. Bits of wider ports on that pad are suppressed.
- R3: Each port has one enable and one direction bit, where direction 1 means output. A port that is enabled as an input never drives or claims a pad.
- R4: Every bit of `padIn` appears, in the same cycle and combinationally, on every port input bit mapped to that pad. This holds whatever the enables, modes and arbitration are.
- R5: A side function that claims a pad overrides all ports and PHY modes on it. The pad then takes that function's `sideOut` and `sideOe` bits and the pull-down is off. When several side functions claim the same pad, the lowest-numbered one wins.
- R6: USB mode takes the 8-bit ports 0 and 1 and the 1-bit ports 4, 5, 7, 8, 9 and 10. A taken bit holds its pad undriven (`padOe` 0, pull-down 0) and blocks wider ports on that pad. The 4-bit ports on the same pads still win.
- R7: MIPI mode takes the 8-bit port 0 and the 1-bit ports 4, 8 and 14, with the same effect as R6. Either takeover applies only while its mode bit is 1. Both modes together take the union of the two sets.
- R8: `padPullDn` is 1 exactly when no side function, no PHY takeover and no enabled output port claims the pad. `padOe` and `padPullDn` are never 1 together.
- R9: A change to an enable, a direction, a side claim or a mode bit reaches the pads after the next rising clock edge, and not before it. A change to port data, `sideOut`, `sideOe` or `padIn` reaches the outputs without any clock edge.
- R10: Port i bit b of a port of width W sits at flat bus bit i*W+b. The pads are mapped as follows:
  - 1-bit port i sits on pad i for i<2, pad i+8 for i<6, pad i+16 for i<10, and pad i+24 otherwise.
  - For 4-bit port i, let g=i/2 and base=2+12g. An odd i puts bit b on pad base+2+b. An even i puts bit b on pad base+b for b<2 and on pad base+4+b otherwise.
  - 8-bit port i<3 puts bit b on pad 2+12i+b. Port 3 puts bit b on pad 36+b.
  - 16-bit port 0 puts bit b on pad 2+b for b<8 and on pad 6+b otherwise. Port 1 puts bit b on pad 26+b for b<8 and on pad 28+b otherwise.
  - 32-bit bit b sits on pad 44+b for b<20, pad b-18 for b<28, and pad b-14 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Asynchronous active-low reset |
| p1En | input | 16 | Enable per 1-bit port |
| p1Dir | input | 16 | Direction per 1-bit port, 1 = output |
| p1Out | input | 16 | Output data of the 1-bit ports |
| p1In | output | 16 | Pad values seen by the 1-bit ports |
| p4En | input | 6 | Enable per 4-bit port |
| p4Dir | input | 6 | Direction per 4-bit port |
| p4Out | input | 24 | Output data of the 4-bit ports, flat |
| p4In | output | 24 | Pad values seen by the 4-bit ports |
| p8En | input | 4 | Enable per 8-bit port |
| p8Dir | input | 4 | Direction per 8-bit port |
| p8Out | input | 32 | Output data of the 8-bit ports |
| p8In | output | 32 | Pad values seen by the 8-bit ports |
| p16En | input | 2 | Enable per 16-bit port |
| p16Dir | input | 2 | Direction per 16-bit port |
| p16Out | input | 32 | Output data of the 16-bit ports |
| p16In | output | 32 | Pad values seen by the 16-bit ports |
| p32En | input | 1 | Enable of the 32-bit port |
| p32Dir | input | 1 | Direction of the 32-bit port |
| p32Out | input | 32 | Output data of the 32-bit port |
| p32In | output | 32 | Pad values seen by the 32-bit port |
| sideEn | input | 3x64 | Per-pad claim of each side function |
| sideOut | input | 3x64 | Per-pad data of each side function |
| sideOe | input | 3x64 | Per-pad drive enable of each side function |
| usbMode | input | 1 | USB takeover mode |
| mipiMode | input | 1 | MIPI takeover mode |
| padIn | input | 64 | Values sampled at the pads |
| padOut | output | 64 | Data driven to the pads |
| padOe | output | 64 | Pad output enable |
| padPullDn | output | 64 | Weak pull-down enable per pad |

## Verification
Configuration inputs are set just after a falling edge. The pad outputs are expected one rising edge later and are sampled at the next falling edge. The bench also checks just before that rising edge that the old result still holds. Data paths and the pad-to-port fan-in are combinational, so the bench checks them a short delay after the input change, with no clock edge in between. The bench's expected pad state comes from its own pad-of-port map and a rank for each source, applied port by port. A walking-one sweep over all pads checks the whole input map.

// File: rtl/padmux_pkg.sv
`timescale 1ns/1ps
package padmux_pkg;
  localparam int NUM_PADS = 64;
  localparam int NUM_P1   = 16;
  localparam int NUM_P4   = 6;
  localparam int NUM_P8   = 4;
  localparam int NUM_P16  = 2;
  localparam int NUM_P32  = 1;
  localparam int NUM_SIDE = 3;
  localparam int SIDE_W   = (NUM_SIDE > 1) ? $clog2(NUM_SIDE) : 1;
  localparam int BUS4     = NUM_P4 * 4;
  localparam int BUS8     = NUM_P8 * 8;
  localparam int BUS16    = NUM_P16 * 16;
  localparam int BUS32    = NUM_P32 * 32;

  // Ports taken over by each PHY mode
  localparam logic [NUM_P1-1:0] USB_TAKE1  = 16'h07B0;
  localparam logic [NUM_P8-1:0] USB_TAKE8  = 4'b0011;
  localparam logic [NUM_P1-1:0] MIPI_TAKE1 = 16'h4110;
  localparam logic [NUM_P8-1:0] MIPI_TAKE8 = 4'b0001;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_SIDE, SRC_PHY, SRC_P1, SRC_P4, SRC_P8, SRC_P16, SRC_P32
  } padSrc_e;

  // Strobe from control to datapath, one per pad
  typedef struct packed {
    padSrc_e             src;
    logic [SIDE_W-1:0]   sideIdx;
  } padSel_t;

  // Nested 8-pad groups shared by 4-, 8- and 16-bit ports
  function automatic int grpOf(int p);
    if (p >= 2 && p <= 9)   return 0;
    if (p >= 14 && p <= 21) return 1;
    if (p >= 26 && p <= 33) return 2;
    return -1;
  endfunction

  function automatic int flat1Of(int p);
    if (p < 2)              return p;
    if (p >= 10 && p <= 13) return p - 8;
    if (p >= 22 && p <= 25) return p - 16;
    if (p >= 34 && p <= 39) return p - 24;
    return -1;
  endfunction

  function automatic int flat4Of(int p);
    int g, off;
    g = grpOf(p);
    if (g < 0) return -1;
    off = p - (2 + 12 * g);
    if (off < 2) return 8 * g + off;
    if (off < 6) return 8 * g + 4 + (off - 2);
    return 8 * g + (off - 4);
  endfunction

  function automatic int flat8Of(int p);
    int g;
    g = grpOf(p);
    if (g >= 0) return 8 * g + (p - (2 + 12 * g));
    if (p >= 36 && p <= 43) return 24 + (p - 36);
    return -1;
  endfunction

  function automatic int flat16Of(int p);
    int g;
    g = grpOf(p);
    if (g >= 0) return 8 * g + (p - (2 + 12 * g));
    if (p >= 36 && p <= 43) return 24 + (p - 36);
    return -1;
  endfunction

  function automatic int flat32Of(int p);
    int g, off;
    if (p >= 44 && p <= 63) return p - 44;
    g = grpOf(p);
    if (g < 0) return -1;
    off = p - (2 + 12 * g);
    if (g == 0) return 20 + off;
    if (g == 1 && off < 4) return 28 + off;
    return -1;
  endfunction
endpackage

// File: rtl/padmux_ctrl.sv
`timescale 1ns/1ps
module padmux_ctrl
  import padmux_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_P1-1:0]                   p1En,
  input  logic [NUM_P1-1:0]                   p1Dir,
  input  logic [NUM_P4-1:0]                   p4En,
  input  logic [NUM_P4-1:0]                   p4Dir,
  input  logic [NUM_P8-1:0]                   p8En,
  input  logic [NUM_P8-1:0]                   p8Dir,
  input  logic [NUM_P16-1:0]                  p16En,
  input  logic [NUM_P16-1:0]                  p16Dir,
  input  logic [NUM_P32-1:0]                  p32En,
  input  logic [NUM_P32-1:0]                  p32Dir,
  input  logic [NUM_SIDE-1:0][NUM_PADS-1:0]   sideEn,
  input  logic                                usbMode,
  input  logic                                mipiMode,
  output padSel_t [NUM_PADS-1:0]              padSel
);
  logic [NUM_P1-1:0]  en1Q, dir1Q;
  logic [NUM_P4-1:0]  en4Q, dir4Q;
  logic [NUM_P8-1:0]  en8Q, dir8Q;
  logic [NUM_P16-1:0] en16Q, dir16Q;
  logic [NUM_P32-1:0] en32Q, dir32Q;
  logic [NUM_SIDE-1:0][NUM_PADS-1:0] sideQ;
  logic usbQ, mipiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en1Q <= '0;  dir1Q <= '0;  en4Q <= '0;  dir4Q <= '0;
      en8Q <= '0;  dir8Q <= '0;  en16Q <= '0; dir16Q <= '0;
      en32Q <= '0; dir32Q <= '0; sideQ <= '0;
      usbQ <= 1'b0; mipiQ <= 1'b0;
    end else begin
      en1Q <= p1En;   dir1Q <= p1Dir;   en4Q <= p4En;   dir4Q <= p4Dir;
      en8Q <= p8En;   dir8Q <= p8Dir;   en16Q <= p16En; dir16Q <= p16Dir;
      en32Q <= p32En; dir32Q <= p32Dir; sideQ <= sideEn;
      usbQ <= usbMode; mipiQ <= mipiMode;
    end
  end

  logic [NUM_P1-1:0]  stolen1, act1;
  logic [NUM_P8-1:0]  stolen8, act8;
  logic [NUM_P4-1:0]  act4;
  logic [NUM_P16-1:0] act16;
  logic [NUM_P32-1:0] act32;

  assign stolen1 = (usbQ ? USB_TAKE1 : '0) | (mipiQ ? MIPI_TAKE1 : '0);
  assign stolen8 = (usbQ ? USB_TAKE8 : '0) | (mipiQ ? MIPI_TAKE8 : '0);
  assign act1    = en1Q & dir1Q & ~stolen1;
  assign act4    = en4Q & dir4Q;
  assign act8    = en8Q & dir8Q & ~stolen8;
  assign act16   = en16Q & dir16Q;
  assign act32   = en32Q & dir32Q;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int F1  = flat1Of(p);
    localparam int F4  = flat4Of(p);
    localparam int F8  = flat8Of(p);
    localparam int F16 = flat16Of(p);
    localparam int F32 = flat32Of(p);

    logic a1, h1, a4, h8, a8, a16, a32, sHit;
    logic [SIDE_W-1:0] sIdx;
    padSel_t selLoc;

    if (F1 >= 0) begin : g_m1
      assign a1 = act1[F1];
      assign h1 = stolen1[F1];
    end else begin : g_n1
      assign a1 = 1'b0;
      assign h1 = 1'b0;
    end
    if (F4 >= 0) begin : g_m4
      assign a4 = act4[F4/4];
    end else begin : g_n4
      assign a4 = 1'b0;
    end
    if (F8 >= 0) begin : g_m8
      assign a8 = act8[F8/8];
      assign h8 = stolen8[F8/8];
    end else begin : g_n8
      assign a8 = 1'b0;
      assign h8 = 1'b0;
    end
    if (F16 >= 0) begin : g_m16
      assign a16 = act16[F16/16];
    end else begin : g_n16
      assign a16 = 1'b0;
    end
    if (F32 >= 0) begin : g_m32
      assign a32 = act32[F32/32];
    end else begin : g_n32
      assign a32 = 1'b0;
    end

    // Lowest-numbered side function has priority
    always_comb begin
      sHit = 1'b0;
      sIdx = '0;
      for (int s = NUM_SIDE - 1; s >= 0; s--) begin
        if (sideQ[s][p]) begin
          sHit = 1'b1;
          sIdx = SIDE_W'(s);
        end
      end
    end

    always_comb begin
      selLoc.sideIdx = sIdx;
      if (sHit)      selLoc.src = SRC_SIDE;
      else if (h1)   selLoc.src = SRC_PHY;
      else if (a1)   selLoc.src = SRC_P1;
      else if (a4)   selLoc.src = SRC_P4;
      else if (h8)   selLoc.src = SRC_PHY;
      else if (a8)   selLoc.src = SRC_P8;
      else if (a16)  selLoc.src = SRC_P16;
      else if (a32)  selLoc.src = SRC_P32;
      else           selLoc.src = SRC_NONE;
    end

    assign padSel[p] = selLoc;

    // R2: a narrow active port keeps wider ports off the pad
    p_narrow_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
      ((a1 || a4) && !sHit && !h1) |-> !(selLoc.src inside {SRC_P8, SRC_P16, SRC_P32}));

    // R7: a taken 1-bit port holds its pad for the PHY unless a side function claims it
    p_phy_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (h1 && !sHit) |-> (selLoc.src == SRC_PHY));

    if (F4 >= 0 && F8 >= 0) begin : g_usbchk
      // R6: 4-bit ports under taken 8-bit ports still reach the pad
      p_usb_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
        (usbQ && a4 && !sHit) |-> (selLoc.src == SRC_P4));
    end
  end
endmodule

// File: rtl/padmux_dp.sv
`timescale 1ns/1ps
module padmux_dp
  import padmux_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  padSel_t [NUM_PADS-1:0]              padSel,
  input  logic [NUM_P1-1:0]                   p1Out,
  input  logic [BUS4-1:0]                     p4Out,
  input  logic [BUS8-1:0]                     p8Out,
  input  logic [BUS16-1:0]                    p16Out,
  input  logic [BUS32-1:0]                    p32Out,
  input  logic [NUM_SIDE-1:0][NUM_PADS-1:0]   sideOut,
  input  logic [NUM_SIDE-1:0][NUM_PADS-1:0]   sideOe,
  input  logic [NUM_PADS-1:0]                 padIn,
  output logic [NUM_PADS-1:0]                 padOut,
  output logic [NUM_PADS-1:0]                 padOe,
  output logic [NUM_PADS-1:0]                 padPullDn,
  output logic [NUM_P1-1:0]                   p1In,
  output logic [BUS4-1:0]                     p4In,
  output logic [BUS8-1:0]                     p8In,
  output logic [BUS16-1:0]                    p16In,
  output logic [BUS32-1:0]                    p32In
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int F1  = flat1Of(p);
    localparam int F4  = flat4Of(p);
    localparam int F8  = flat8Of(p);
    localparam int F16 = flat16Of(p);
    localparam int F32 = flat32Of(p);

    logic d1, d4, d8, d16, d32, outLoc, oeLoc;

    if (F1 >= 0) begin : g_m1
      assign d1 = p1Out[F1];
      assign p1In[F1] = padIn[p];
    end else begin : g_n1
      assign d1 = 1'b0;
    end
    if (F4 >= 0) begin : g_m4
      assign d4 = p4Out[F4];
      assign p4In[F4] = padIn[p];
    end else begin : g_n4
      assign d4 = 1'b0;
    end
    if (F8 >= 0) begin : g_m8
      assign d8 = p8Out[F8];
      assign p8In[F8] = padIn[p];
    end else begin : g_n8
      assign d8 = 1'b0;
    end
    if (F16 >= 0) begin : g_m16
      assign d16 = p16Out[F16];
      assign p16In[F16] = padIn[p];
    end else begin : g_n16
      assign d16 = 1'b0;
    end
    if (F32 >= 0) begin : g_m32
      assign d32 = p32Out[F32];
      assign p32In[F32] = padIn[p];
    end else begin : g_n32
      assign d32 = 1'b0;
    end

    always_comb begin
      outLoc = 1'b0;
      oeLoc  = 1'b0;
      case (padSel[p].src)
        SRC_SIDE: begin
          outLoc = sideOut[padSel[p].sideIdx][p];
          oeLoc  = sideOe[padSel[p].sideIdx][p];
        end
        SRC_P1:  begin outLoc = d1;  oeLoc = 1'b1; end
        SRC_P4:  begin outLoc = d4;  oeLoc = 1'b1; end
        SRC_P8:  begin outLoc = d8;  oeLoc = 1'b1; end
        SRC_P16: begin outLoc = d16; oeLoc = 1'b1; end
        SRC_P32: begin outLoc = d32; oeLoc = 1'b1; end
        default: ;
      endcase
    end

    assign padOut[p]    = outLoc;
    assign padOe[p]     = oeLoc;
    assign padPullDn[p] = (padSel[p].src == SRC_NONE);
  end

  // R8: pull-down and drive never overlap
  p_pull_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padPullDn) == '0);

  // R1: first cycle out of reset the pads are idle and pulled down
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && padPullDn == '1));
endmodule

// File: rtl/padmux_top.sv
`timescale 1ns/1ps
module padmux_top
  import padmux_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_P1-1:0]                   p1En,
  input  logic [NUM_P1-1:0]                   p1Dir,
  input  logic [NUM_P1-1:0]                   p1Out,
  output logic [NUM_P1-1:0]                   p1In,
  input  logic [NUM_P4-1:0]                   p4En,
  input  logic [NUM_P4-1:0]                   p4Dir,
  input  logic [BUS4-1:0]                     p4Out,
  output logic [BUS4-1:0]                     p4In,
  input  logic [NUM_P8-1:0]                   p8En,
  input  logic [NUM_P8-1:0]                   p8Dir,
  input  logic [BUS8-1:0]                     p8Out,
  output logic [BUS8-1:0]                     p8In,
  input  logic [NUM_P16-1:0]                  p16En,
  input  logic [NUM_P16-1:0]                  p16Dir,
  input  logic [BUS16-1:0]                    p16Out,
  output logic [BUS16-1:0]                    p16In,
  input  logic [NUM_P32-1:0]                  p32En,
  input  logic [NUM_P32-1:0]                  p32Dir,
  input  logic [BUS32-1:0]                    p32Out,
  output logic [BUS32-1:0]                    p32In,
  input  logic [NUM_SIDE-1:0][NUM_PADS-1:0]   sideEn,
  input  logic [NUM_SIDE-1:0][NUM_PADS-1:0]   sideOut,
  input  logic [NUM_SIDE-1:0][NUM_PADS-1:0]   sideOe,
  input  logic                                usbMode,
  input  logic                                mipiMode,
  input  logic [NUM_PADS-1:0]                 padIn,
  output logic [NUM_PADS-1:0]                 padOut,
  output logic [NUM_PADS-1:0]                 padOe,
  output logic [NUM_PADS-1:0]                 padPullDn
);
  padSel_t [NUM_PADS-1:0] padSel;

  padmux_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .p1En(p1En), .p1Dir(p1Dir), .p4En(p4En), .p4Dir(p4Dir),
    .p8En(p8En), .p8Dir(p8Dir), .p16En(p16En), .p16Dir(p16Dir),
    .p32En(p32En), .p32Dir(p32Dir), .sideEn(sideEn),
    .usbMode(usbMode), .mipiMode(mipiMode), .padSel(padSel)
  );

  padmux_dp dp_i (
    .clk(clk), .rstN(rstN), .padSel(padSel),
    .p1Out(p1Out), .p4Out(p4Out), .p8Out(p8Out), .p16Out(p16Out), .p32Out(p32Out),
    .sideOut(sideOut), .sideOe(sideOe), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPullDn(padPullDn),
    .p1In(p1In), .p4In(p4In), .p8In(p8In), .p16In(p16In), .p32In(p32In)
  );
endmodule

// File: tb/padmux_top_tb_top.sv
`timescale 1ns/1ps
module padmux_top_tb_top;
  import padmux_pkg::*;

  localparam logic [15:0] TB_USB1  = 16'h07B0; // 1-bit ports 4,5,7,8,9,10
  localparam logic [3:0]  TB_USB8  = 4'b0011;  // 8-bit ports 0,1
  localparam logic [15:0] TB_MIPI1 = 16'h4110; // 1-bit ports 4,8,14
  localparam logic [3:0]  TB_MIPI8 = 4'b0001;  // 8-bit port 0

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_P1-1:0]  p1En = '0, p1Dir = '0, p1Out = '0, p1In;
  logic [NUM_P4-1:0]  p4En = '0, p4Dir = '0;
  logic [BUS4-1:0]    p4Out = '0, p4In;
  logic [NUM_P8-1:0]  p8En = '0, p8Dir = '0;
  logic [BUS8-1:0]    p8Out = '0, p8In;
  logic [NUM_P16-1:0] p16En = '0, p16Dir = '0;
  logic [BUS16-1:0]   p16Out = '0, p16In;
  logic [NUM_P32-1:0] p32En = '0, p32Dir = '0;
  logic [BUS32-1:0]   p32Out = '0, p32In;
  logic [NUM_SIDE-1:0][NUM_PADS-1:0] sideEn = '0, sideOut = '0, sideOe = '0;
  logic usbMode = 1'b0, mipiMode = 1'b0;
  logic [NUM_PADS-1:0] padIn = '0, padOut, padOe, padPullDn;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  padmux_top dut_i (
    .clk(clk), .rstN(rstN),
    .p1En(p1En), .p1Dir(p1Dir), .p1Out(p1Out), .p1In(p1In),
    .p4En(p4En), .p4Dir(p4Dir), .p4Out(p4Out), .p4In(p4In),
    .p8En(p8En), .p8Dir(p8Dir), .p8Out(p8Out), .p8In(p8In),
    .p16En(p16En), .p16Dir(p16Dir), .p16Out(p16Out), .p16In(p16In),
    .p32En(p32En), .p32Dir(p32Dir), .p32Out(p32Out), .p32In(p32In),
    .sideEn(sideEn), .sideOut(sideOut), .sideOe(sideOe),
    .usbMode(usbMode), .mipiMode(mipiMode),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPullDn(padPullDn)
  );

  // Pad of each port bit (R10)
  function automatic int pad1(int i);
    if (i < 2)  return i;
    if (i < 6)  return i + 8;
    if (i < 10) return i + 16;
    return i + 24;
  endfunction
  function automatic int pad4(int i, int b);
    int base;
    base = 2 + 12 * (i / 2);
    if (i % 2 == 1) return base + 2 + b;
    return (b < 2) ? base + b : base + 4 + b;
  endfunction
  function automatic int pad8(int i, int b);
    return (i < 3) ? 2 + 12 * i + b : 36 + b;
  endfunction
  function automatic int pad16(int i, int b);
    if (i == 0) return (b < 8) ? 2 + b : 6 + b;
    return (b < 8) ? 26 + b : 28 + b;
  endfunction
  function automatic int pad32(int b);
    if (b < 20) return 44 + b;
    if (b < 28) return b - 18;
    return b - 14;
  endfunction

  int rankT [NUM_PADS];
  logic [NUM_PADS-1:0] expOut, expOe, expPd;

  task automatic offer(int pd, int r, logic d, logic oe);
    if (r < rankT[pd]) begin
      rankT[pd] = r;
      expOut[pd] = d;
      expOe[pd] = oe;
    end
  endtask

  task automatic computeExp();
    logic [15:0] st1;
    logic [3:0]  st8;
    st1 = (usbMode ? TB_USB1 : 16'h0) | (mipiMode ? TB_MIPI1 : 16'h0);
    st8 = (usbMode ? TB_USB8 : 4'h0) | (mipiMode ? TB_MIPI8 : 4'h0);
    for (int p = 0; p < NUM_PADS; p++) begin
      rankT[p] = 99; expOut[p] = 1'b0; expOe[p] = 1'b0;
    end
    for (int s = 0; s < NUM_SIDE; s++)
      for (int p = 0; p < NUM_PADS; p++)
        if (sideEn[s][p]) offer(p, s, sideOut[s][p], sideOe[s][p]);
    for (int i = 0; i < NUM_P1; i++) begin
      if (st1[i]) offer(pad1(i), 10, 1'b0, 1'b0);
      else if (p1En[i] && p1Dir[i]) offer(pad1(i), 11, p1Out[i], 1'b1);
    end
    for (int i = 0; i < NUM_P4; i++)
      for (int b = 0; b < 4; b++)
        if (p4En[i] && p4Dir[i]) offer(pad4(i, b), 12, p4Out[i*4+b], 1'b1);
    for (int i = 0; i < NUM_P8; i++)
      for (int b = 0; b < 8; b++) begin
        if (st8[i]) offer(pad8(i, b), 13, 1'b0, 1'b0);
        else if (p8En[i] && p8Dir[i]) offer(pad8(i, b), 14, p8Out[i*8+b], 1'b1);
      end
    for (int i = 0; i < NUM_P16; i++)
      for (int b = 0; b < 16; b++)
        if (p16En[i] && p16Dir[i]) offer(pad16(i, b), 15, p16Out[i*16+b], 1'b1);
    for (int b = 0; b < 32; b++)
      if (p32En[0] && p32Dir[0]) offer(pad32(b), 16, p32Out[b], 1'b1);
    for (int p = 0; p < NUM_PADS; p++) expPd[p] = (rankT[p] == 99);
  endtask

  task automatic chk(string tag);
    computeExp();
    nChecks++;
    if (padOut !== expOut || padOe !== expOe || padPullDn !== expPd) begin
      nBad++;
      $display("FAIL %s out=%h exp=%h oe=%h exp=%h pd=%h exp=%h",
               tag, padOut, expOut, padOe, expOe, padPullDn, expPd);
    end
  endtask

  task automatic applyCfg();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearCfg();
    p1En = '0; p1Dir = '0; p4En = '0; p4Dir = '0; p8En = '0; p8Dir = '0;
    p16En = '0; p16Dir = '0; p32En = '0; p32Dir = '0;
    sideEn = '0; usbMode = 1'b0; mipiMode = 1'b0;
  endtask

  task automatic allOut();
    p1En = '1; p1Dir = '1; p4En = '1; p4Dir = '1; p8En = '1; p8Dir = '1;
    p16En = '1; p16Dir = '1; p32En = '1; p32Dir = '1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  endtask

  initial begin
    #500000;
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [NUM_PADS-1:0] snapOut, snapOe, snapPd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk("R1 reset idle");

    // R4/R10: walking one over every pad, with an arbitrary config applied
    allOut(); usbMode = 1'b1; applyCfg();
    for (int p = 0; p < NUM_PADS; p++) begin
      logic [NUM_P1-1:0] e1; logic [BUS4-1:0] e4; logic [BUS8-1:0] e8;
      logic [BUS16-1:0] e16; logic [BUS32-1:0] e32;
      padIn = 64'd1 << p;
      #1;
      for (int i = 0; i < NUM_P1; i++) e1[i] = (pad1(i) == p);
      for (int i = 0; i < NUM_P4; i++) for (int b = 0; b < 4; b++) e4[i*4+b] = (pad4(i, b) == p);
      for (int i = 0; i < NUM_P8; i++) for (int b = 0; b < 8; b++) e8[i*8+b] = (pad8(i, b) == p);
      for (int i = 0; i < NUM_P16; i++) for (int b = 0; b < 16; b++) e16[i*16+b] = (pad16(i, b) == p);
      for (int b = 0; b < 32; b++) e32[b] = (pad32(b) == p);
      nChecks++;
      if ({p1In, p4In, p8In, p16In, p32In} !== {e1, e4, e8, e16, e32}) begin
        nBad++;
        $display("FAIL R4 R10 pad %0d act=%h exp=%h", p,
                 {p1In, p4In, p8In, p16In, p32In}, {e1, e4, e8, e16, e32});
      end
    end
    padIn = '0;
    @(negedge clk);

    // R2: all ports out with width-coded data
    clearCfg(); allOut();
    p1Out = '1; p4Out = '0; p8Out = '1; p16Out = '0; p32Out = '1;
    applyCfg();
    chk("R2 R10 all widths out");
    p1En = '0; p4En = '0; applyCfg();
    chk("R2 eight-bit over wider");
    p8En = '0; applyCfg();
    chk("R2 sixteen over thirty-two");
    p16En = '0; applyCfg();
    chk("R2 thirty-two alone");

    // R3: ports enabled but as inputs
    allOut(); p1Dir = '0; p4Dir = '0; p8Dir = '0; p16Dir = '0; p32Dir = '0;
    applyCfg();
    chk("R3 inputs never drive");
    p4Dir = 6'b000010; applyCfg();
    chk("R3 one port out");

    // R5: overlapping side functions
    allOut();
    sideEn[0] = 64'h0000_0000_0000_0060; sideOut[0] = '1; sideOe[0] = '1;
    sideEn[1] = 64'h0000_0000_0000_00F0; sideOut[1] = '0; sideOe[1] = '1;
    sideEn[2] = 64'h8000_0000_0000_0001; sideOut[2] = '1; sideOe[2] = '0;
    applyCfg();
    chk("R5 side priority and override");

    // R6, R7: PHY takeovers
    clearCfg(); allOut(); usbMode = 1'b1; applyCfg();
    chk("R6 usb takeover");
    p4En = '0; applyCfg();
    chk("R6 usb holds eight-bit pads");
    allOut(); usbMode = 1'b0; mipiMode = 1'b1; applyCfg();
    chk("R7 mipi takeover");
    usbMode = 1'b1; applyCfg();
    chk("R7 both modes");
    // R8: pad of 1-bit port 8 held by PHY: undriven, no pull
    nChecks++;
    if (padOe[24] !== 1'b0 || padPullDn[24] !== 1'b0) begin
      nBad++;
      $display("FAIL R8 phy pad oe=%b exp=0 pd=%b exp=0", padOe[24], padPullDn[24]);
    end
    mipiMode = 1'b0; usbMode = 1'b0; applyCfg();
    chk("R7 mode released");

    // R9: configuration latency versus immediate data
    clearCfg(); applyCfg();
    snapOut = padOut; snapOe = padOe; snapPd = padPullDn;
    p1En[0] = 1'b1; p1Dir[0] = 1'b1; p1Out[0] = 1'b1;
    #1;
    nChecks++;
    if (padOut !== snapOut || padOe !== snapOe || padPullDn !== snapPd) begin
      nBad++;
      $display("FAIL R9 before edge oe=%h exp=%h", padOe, snapOe);
    end
    applyCfg();
    chk("R9 after edge");
    p1Out[0] = 1'b0;
    #1;
    chk("R9 data without edge");
    @(negedge clk);

    // Random sweep
    for (int n = 0; n < 400; n++) begin
      p1En = 16'($urandom); p1Dir = 16'($urandom); p1Out = 16'($urandom);
      p4En = 6'($urandom);  p4Dir = 6'($urandom);  p4Out = 24'($urandom);
      p8En = 4'($urandom);  p8Dir = 4'($urandom);  p8Out = $urandom;
      p16En = 2'($urandom); p16Dir = 2'($urandom); p16Out = $urandom;
      p32En = 1'($urandom); p32Dir = 1'($urandom); p32Out = $urandom;
      for (int s = 0; s < NUM_SIDE; s++) begin
        sideEn[s]  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
        sideOut[s] = {$urandom, $urandom};
        sideOe[s]  = {$urandom, $urandom};
      end
      usbMode = 1'($urandom); mipiMode = 1'($urandom);
      padIn = {$urandom, $urandom};
      applyCfg();
      chk("R2 R3 R5 R6 R7 R8 random");
    end

    finishRun();
  end
endmodule